// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block is the fetch stage of a simple sequential 64-bit processor. It holds the program counter in a register that updates only on a rising clock edge. It places that counter on a byte-addressed instruction memory port. The port returns ten consecutive bytes, and from them the block decodes one instruction of one, two, nine or ten bytes.

The decoding is purely combinational. The opcode byte is split into an instruction code and a function code. The block then decides whether a register-specifier byte follows and whether an 8-byte constant follows. The constant sits right after the opcode byte or right after the register byte, depending on the instruction. Finally the block computes the address of the next sequential instruction.

The flags that mark an undefined encoding or a halt let the surrounding pipeline stop cleanly. Choosing the next program counter is left to the stages that follow. They return the chosen value through the load input.

Top module: `fetch_decoder`

## Requirements
- R1: The program counter resets to zero and is driven on `imem_addr`. On a rising clock edge it takes `pc_next` when `pc_load` is 1, and it keeps its value when `pc_load` is 0.
- R2: `icode` is bits 7:4 and `ifun` is bits 3:0 of the opcode byte. The opcode byte is byte 0 of `imem_bytes`, at bits 7:0. Byte k sits at bits 8k+7:8k and comes from address `imem_addr`+k.
- R3: Codes 0x0, 0x1 and 0x9 are one byte long. For them `ra` and `rb` are 0xF, `valc` is 0 and `valp` is the PC plus 1.
- R4: Codes 0x2, 0x6, 0xA and 0xB are two bytes long. For them `ra` is bits 7:4 and `rb` is bits 3:0 of byte 1, `valc` is 0 and `valp` is the PC plus 2.
- R5: Codes 0x3, 0x4 and 0x5 are ten bytes long. For them `ra` and `rb` come from byte 1 as in R4. `valc` is bytes 2 to 9 in little-endian order, with byte 2 least significant. `valp` is the PC plus 10.
- R6: Codes 0x7 and 0x8 are nine bytes long and have no register byte. For them `ra` and `rb` are 0xF. `valc` is bytes 1 to 8 in little-endian order, with byte 1 least significant. `valp` is the PC plus 9.
- R7: Codes 0xC to 0xF raise `instr_invalid`. They are treated as one byte long: `ra` and `rb` are 0xF, `valc` is 0 and `valp` is the PC plus 1.
- R8: Among codes 0x0 to 0xB, `instr_invalid` follows the function code. Code 0x6 accepts function codes 0 to 3. Codes 0x2 and 0x7 accept function codes 0 to 6. Every other defined code accepts only function code 0. A rejected function code does not change the length or the fields.
- R9: `halt` is 1 exactly when `icode` is 0, whatever the function code.
- R10: `valp` is computed modulo 2^64, so an instruction that ends past the top of the address space gives a small wrapped `valp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_load | input | 1 | Load `pc_next` into the program counter |
| pc_next | input | 64 | Next program counter value |
| imem_addr | output | 64 | Current program counter, address of byte 0 |
| imem_bytes | input | 80 | Ten instruction bytes starting at `imem_addr` |
| icode | output | 4 | Instruction code |
| ifun | output | 4 | Function code |
| ra | output | 4 | First register specifier, 0xF if absent |
| rb | output | 4 | Second register specifier, 0xF if absent |
| valc | output | 64 | Constant or displacement, 0 if absent |
| valp | output | 64 | Address of the next sequential instruction |
| instr_invalid | output | 1 | Undefined instruction or function code |
| halt | output | 1 | Halt instruction present |

## Verification
The hardest case to reach from the ports is a nine- or ten-byte instruction that starts within ten bytes of the top of the 64-bit address space. There `valp` must wrap while the constant bytes still come out in the right order. The bench loads the counter with values just below 2^64 and places jump, call and immediate-move opcodes there. A sweep of all 256 opcode byte values reaches every rejected function code. A walk that follows the model's own next address steps through mixed-length code.

// File: rtl/fetchdec_pkg.sv
package fetchdec_pkg;

   typedef enum logic [3:0] {
      OP_HALT  = 4'h0,
      OP_NOP   = 4'h1,
      OP_CMOV  = 4'h2,
      OP_IRMOV = 4'h3,
      OP_RMMOV = 4'h4,
      OP_MRMOV = 4'h5,
      OP_ALU   = 4'h6,
      OP_JUMP  = 4'h7,
      OP_CALL  = 4'h8,
      OP_RET   = 4'h9,
      OP_PUSH  = 4'hA,
      OP_POP   = 4'hB
   } opcode_e;

   localparam logic [3:0] NO_REG      = 4'hF;
   localparam logic [3:0] ALU_FN_MAX  = 4'd3;
   localparam logic [3:0] COND_FN_MAX = 4'd6;

   typedef struct packed {
      logic has_reg;
      logic has_const;
      logic code_ok;
      logic fn_ok;
   } op_class_t;

endpackage

// File: rtl/fd_pc_reg.sv
module fd_pc_reg #(
   parameter int                ADDR_W   = 64,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] next_val,
   output logic [ADDR_W-1:0] pc
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc <= RESET_PC;
      else if (load)
         pc <= next_val;
   end

endmodule

// File: rtl/fd_op_class.sv
module fd_op_class
   import fetchdec_pkg::*;
(
   input  logic [3:0] code,
   input  logic [3:0] fn,
   output op_class_t  cls
);

   always_comb begin
      cls = '{has_reg: 1'b0, has_const: 1'b0, code_ok: 1'b1, fn_ok: (fn == 4'd0)};
      case (code)
         OP_HALT, OP_NOP, OP_RET: ;
         OP_CMOV: begin
            cls.has_reg = 1'b1;
            cls.fn_ok   = (fn <= COND_FN_MAX);
         end
         OP_ALU: begin
            cls.has_reg = 1'b1;
            cls.fn_ok   = (fn <= ALU_FN_MAX);
         end
         OP_PUSH, OP_POP: cls.has_reg = 1'b1;
         OP_IRMOV, OP_RMMOV, OP_MRMOV: begin
            cls.has_reg   = 1'b1;
            cls.has_const = 1'b1;
         end
         OP_JUMP: begin
            cls.has_const = 1'b1;
            cls.fn_ok     = (fn <= COND_FN_MAX);
         end
         OP_CALL: cls.has_const = 1'b1;
         default: begin
            cls.code_ok = 1'b0;
            cls.fn_ok   = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/fd_field_extract.sv
module fd_field_extract
   import fetchdec_pkg::*;
#(
   parameter int WORD_W      = 64,
   parameter int FETCH_BYTES = 10
) (
   input  logic [FETCH_BYTES*8-1:0] bytes_in,
   input  logic                     has_reg,
   input  logic                     has_const,
   output logic [3:0]               code,
   output logic [3:0]               fn,
   output logic [3:0]               ra,
   output logic [3:0]               rb,
   output logic [WORD_W-1:0]        valc
);

   localparam int CONST_BYTES = WORD_W / 8;

   logic [WORD_W-1:0] const_after_op;
   logic [WORD_W-1:0] const_after_reg;

   assign code = bytes_in[7:4];
   assign fn   = bytes_in[3:0];

   // constant bytes are little-endian: lowest address is least significant
   for (genvar k = 0; k < CONST_BYTES; k++) begin : g_const_byte
      assign const_after_op[k*8 +: 8]  = bytes_in[(1 + k)*8 +: 8];
      assign const_after_reg[k*8 +: 8] = bytes_in[(2 + k)*8 +: 8];
   end

   always_comb begin
      ra = NO_REG;
      rb = NO_REG;
      if (has_reg) begin
         ra = bytes_in[15:12];
         rb = bytes_in[11:8];
      end
   end

   always_comb begin
      if (!has_const)
         valc = '0;
      else if (has_reg)
         valc = const_after_reg;
      else
         valc = const_after_op;
   end

endmodule

// File: rtl/fd_next_pc.sv
module fd_next_pc #(
   parameter int ADDR_W      = 64,
   parameter int CONST_BYTES = 8
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic              has_reg,
   input  logic              has_const,
   output logic [ADDR_W-1:0] valp
);

   localparam int LEN_W = $clog2(CONST_BYTES + 3);

   logic [LEN_W-1:0] len;

   always_comb begin
      len = LEN_W'(1) + LEN_W'(has_reg);
      if (has_const)
         len = len + LEN_W'(CONST_BYTES);
   end

   assign valp = pc + ADDR_W'(len);

endmodule

// File: rtl/fetch_decoder.sv
module fetch_decoder
   import fetchdec_pkg::*;
#(
   parameter int                ADDR_W      = 64,
   parameter int                WORD_W      = 64,
   parameter int                FETCH_BYTES = 10,
   parameter logic [ADDR_W-1:0] RESET_PC    = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     pc_load,
   input  logic [ADDR_W-1:0]        pc_next,
   output logic [ADDR_W-1:0]        imem_addr,
   input  logic [FETCH_BYTES*8-1:0] imem_bytes,
   output logic [3:0]               icode,
   output logic [3:0]               ifun,
   output logic [3:0]               ra,
   output logic [3:0]               rb,
   output logic [WORD_W-1:0]        valc,
   output logic [ADDR_W-1:0]        valp,
   output logic                     instr_invalid,
   output logic                     halt
);

   localparam int CONST_BYTES = WORD_W / 8;
   localparam int MAX_LEN     = 2 + CONST_BYTES;

   if (WORD_W % 8 != 0) begin : g_bad_word
      $error("WORD_W must be a whole number of bytes");
   end
   if (FETCH_BYTES != MAX_LEN) begin : g_bad_fetch
      $error("FETCH_BYTES must equal the longest instruction length");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W too small");
   end

   op_class_t cls;

   fd_pc_reg #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) i_pc (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (pc_load),
      .next_val (pc_next),
      .pc       (imem_addr)
   );

   fd_field_extract #(.WORD_W(WORD_W), .FETCH_BYTES(FETCH_BYTES)) i_fields (
      .bytes_in  (imem_bytes),
      .has_reg   (cls.has_reg),
      .has_const (cls.has_const),
      .code      (icode),
      .fn        (ifun),
      .ra        (ra),
      .rb        (rb),
      .valc      (valc)
   );

   fd_op_class i_class (
      .code (icode),
      .fn   (ifun),
      .cls  (cls)
   );

   fd_next_pc #(.ADDR_W(ADDR_W), .CONST_BYTES(CONST_BYTES)) i_next (
      .pc        (imem_addr),
      .has_reg   (cls.has_reg),
      .has_const (cls.has_const),
      .valp      (valp)
   );

   assign instr_invalid = !cls.code_ok || !cls.fn_ok;
   assign halt          = (icode == OP_HALT);

endmodule

// File: rtl/fetch_decoder_chk.sv
module fetch_decoder_chk #(
   parameter int ADDR_W = 64,
   parameter int WORD_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pc_load,
   input logic [ADDR_W-1:0] pc_next,
   input logic [ADDR_W-1:0] imem_addr,
   input logic [3:0]        icode,
   input logic [3:0]        ra,
   input logic [3:0]        rb,
   input logic [WORD_W-1:0] valc,
   input logic [ADDR_W-1:0] valp,
   input logic              instr_invalid,
   input logic              halt
);

   a_r1_pc_load: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> imem_addr == $past(pc_next));

   a_r1_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !pc_load |=> $stable(imem_addr));

   a_r3_short: assert property (@(posedge clk) disable iff (!rst_n)
      (icode == 4'h0 || icode == 4'h1 || icode == 4'h9) |->
         (ra == 4'hF && rb == 4'hF && valc == '0 && valp == imem_addr + ADDR_W'(1)));

   a_r4_two_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (icode == 4'h2 || icode == 4'h6 || icode == 4'hA || icode == 4'hB) |->
         (valc == '0 && valp == imem_addr + ADDR_W'(2)));

   a_r5_ten_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (icode == 4'h3 || icode == 4'h4 || icode == 4'h5) |->
         valp == imem_addr + ADDR_W'(10));

   a_r6_nine_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (icode == 4'h7 || icode == 4'h8) |->
         (ra == 4'hF && rb == 4'hF && valp == imem_addr + ADDR_W'(9)));

   a_r7_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
      (icode > 4'hB) |->
         (instr_invalid && valc == '0 && valp == imem_addr + ADDR_W'(1)));

   a_r9_halt: assert property (@(posedge clk) disable iff (!rst_n)
      halt == (icode == 4'h0));

endmodule

bind fetch_decoder fetch_decoder_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .pc_load       (pc_load),
   .pc_next       (pc_next),
   .imem_addr     (imem_addr),
   .icode         (icode),
   .ra            (ra),
   .rb            (rb),
   .valc          (valc),
   .valp          (valp),
   .instr_invalid (instr_invalid),
   .halt          (halt)
);

// File: tb/test_fetch_decoder.sv
module test_fetch_decoder;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        pc_load;
   logic [63:0] pc_next;
   logic [63:0] imem_addr;
   logic [79:0] imem_bytes;
   logic [3:0]  icode, ifun, ra, rb;
   logic [63:0] valc, valp;
   logic        instr_invalid, halt;

   always #5 clk = ~clk;

   fetch_decoder i_fetch_decoder (
      .clk(clk), .rst_n(rst_n), .pc_load(pc_load), .pc_next(pc_next),
      .imem_addr(imem_addr), .imem_bytes(imem_bytes), .icode(icode), .ifun(ifun),
      .ra(ra), .rb(rb), .valc(valc), .valp(valp),
      .instr_invalid(instr_invalid), .halt(halt)
   );

   logic [7:0] mem [256];

   always_comb begin
      for (int k = 0; k < 10; k++)
         imem_bytes[k*8 +: 8] = mem[8'(imem_addr[7:0] + 8'(k))];
   end

   int          n_run  = 0;
   int          n_fail = 0;
   logic [63:0] mpc;
   logic [63:0] exp_valp;
   bit          finished = 0;

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h (pc=%h)", req, what, act, exp, mpc);
      end
   endtask

   // behavioural reference: decode straight from the bench memory
   task automatic compare_all();
      logic [7:0]  b [10];
      logic [3:0]  c, f, er, erb;
      logic [63:0] ev;
      logic [64:0] sum;
      int          len;
      bit          fnok;
      string       rq;
      for (int k = 0; k < 10; k++) b[k] = mem[8'(mpc[7:0] + 8'(k))];
      c = b[0][7:4];
      f = b[0][3:0];
      case (c)
         4'h0, 4'h1, 4'h9:         begin len = 1;  rq = "R3"; end
         4'h2, 4'h6, 4'hA, 4'hB:   begin len = 2;  rq = "R4"; end
         4'h3, 4'h4, 4'h5:         begin len = 10; rq = "R5"; end
         4'h7, 4'h8:               begin len = 9;  rq = "R6"; end
         default:                  begin len = 1;  rq = "R7"; end
      endcase
      er = 4'hF; erb = 4'hF; ev = '0;
      if (len == 2 || len == 10) begin er = b[1][7:4]; erb = b[1][3:0]; end
      if (len == 10) for (int k = 0; k < 8; k++) ev[k*8 +: 8] = b[2+k];
      if (len == 9)  for (int k = 0; k < 8; k++) ev[k*8 +: 8] = b[1+k];
      if (c == 4'h6)                      fnok = (f <= 4'd3);
      else if (c == 4'h2 || c == 4'h7)    fnok = (f <= 4'd6);
      else                                fnok = (f == 4'd0);
      sum      = {1'b0, mpc} + 65'(len);
      exp_valp = sum[63:0];
      chk("R1", "imem_addr", imem_addr, mpc);
      chk("R2", "icode", 64'(icode), 64'(c));
      chk("R2", "ifun", 64'(ifun), 64'(f));
      chk(rq, "ra", 64'(ra), 64'(er));
      chk(rq, "rb", 64'(rb), 64'(erb));
      chk(rq, "valc", valc, ev);
      chk(sum[64] ? "R10" : rq, "valp", valp, exp_valp);
      chk(c > 4'hB ? "R7" : "R8", "instr_invalid", 64'(instr_invalid),
          64'(c > 4'hB || !fnok));
      chk("R9", "halt", 64'(halt), 64'(c == 4'h0));
   endtask

   task automatic step(logic l, logic [63:0] v);
      pc_load = l;
      pc_next = v;
      @(posedge clk);
      if (l) mpc = v;
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n   = 1'b0;
      pc_load = 1'b1;
      pc_next = 64'h55;
      mpc     = '0;
      for (int a = 0; a < 256; a++) mem[a] = 8'h10;
      repeat (3) @(negedge clk);
      chk("R1", "reset imem_addr", imem_addr, 64'h0);
      pc_load = 1'b0;
      rst_n   = 1'b1;
      @(negedge clk);
      compare_all();

      // every opcode byte value, with distinct following bytes
      for (int k = 1; k < 10; k++) mem[8'h40 + k] = 8'(k * 8'h11 + 3);
      for (int op = 0; op < 256; op++) begin
         mem[8'h40] = 8'(op);
         step(1'b1, 64'h40);
      end

      // R1 hold: counter must not move without a load
      step(1'b0, 64'h99);
      step(1'b0, 64'h12);

      // R10 wrap near the top of the address space
      for (int a = 0; a < 256; a++) mem[a] = 8'(a ^ 8'hA5);
      mem[8'hF8] = 8'h70;
      step(1'b1, 64'hFFFF_FFFF_FFFF_FFF8);
      mem[8'hF9] = 8'h30;
      step(1'b1, 64'hFFFF_FFFF_FFFF_FFF9);
      mem[8'hFF] = 8'h10;
      step(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
      mem[8'hFE] = 8'h80;
      step(1'b1, 64'hFFFF_FFFF_FFFF_FFFE);
      mem[8'hFA] = 8'h61;
      step(1'b1, 64'hFFFF_FFFF_FFFF_FFFA);

      // sequential walk through mixed-length valid code
      begin
         logic [7:0] ops [12];
         ops = '{8'h00, 8'h10, 8'h22, 8'h30, 8'h40, 8'h50,
                 8'h63, 8'h76, 8'h80, 8'h90, 8'hA0, 8'hB0};
         for (int a = 0; a < 256; a++) mem[a] = 8'($urandom);
         for (int i = 0; i < 60; i++) begin
            mem[mpc[7:0]] = ops[$urandom % 12];
            step(1'b1, exp_valp);
         end
      end

      // random bytes at random addresses
      for (int i = 0; i < 400; i++) begin
         if (i % 50 == 0)
            for (int a = 0; a < 256; a++) mem[a] = 8'($urandom);
         step(1'b1, {32'($urandom), 32'($urandom)});
         if (i % 7 == 0) step(1'b0, 64'($urandom));
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule